// File: doc/BRIEF.md
# Quad Prescaled Countdown Timer Bank

The block holds four independent down-counters that share one register port. The address selects the timer and the register inside that timer. Each timer counts down by one on a rate pulse. The rate is either every clock, one clock in 16, or one clock in 256. A single free-running divider makes all three rates.

When a running counter reaches zero it stops there and disarms. If its enable bit is set, it raises its own interrupt line. Software acknowledges the interrupt by touching the timer's clear register. In periodic mode that same access reloads the counter and starts it again. A one-shot timer waits at zero until software writes its load or control register.

Top module: `cdt_bank`

## Requirements
- R1: `bus_addr[6:5]` picks timer 0..3. `bus_addr[4:2]` picks the register: 0 load, 1 value, 2 control, 3 clear. Codes 4..7 are unmapped: they read as 0 and ignore writes. A read of clear returns 0.
- R2: Control bits are: bit0 interrupt enable, bit1 periodic, bit2 divide-by-16, bit3 divide-by-256. Reset leaves every timer with control 0x2, load 0xFFFFFF, value 0, disarmed, and no interrupt pending.
- R3: A load write keeps the low 24 data bits in both load and value. It arms the timer and drops that timer's pending interrupt.
- R4: A value write replaces the counter with the low 24 data bits. It changes neither the load register nor whether the timer is armed.
- R5: Any accepted control write drops that timer's pending interrupt. When the written enable bit is 1, the write also copies load into the counter and arms the timer.
- R6: A control write with bits 2 and 3 both set is rejected and changes nothing. `cfg_err` is high for exactly the one cycle after that write.
- R7: An armed timer steps down by one on every clock with no divide bit set. With bit2 set it steps once in every 16 clocks, and with bit3 set once in every 256 clocks.
- R8: On reaching zero the counter stays at 0 without wrapping and the timer disarms. The interrupt is set only when enable is 1, and it stays set until acknowledged.
- R9: Any read or write of clear drops the pending interrupt. In periodic mode it also reloads the counter from load and arms the timer. A one-shot timer stays at 0.
- R10: A load, value, accepted control or clear access to a timer takes precedence over that timer's count step in the same cycle. The step is discarded.
- R11: The four timers run independently, and `irq[i]` belongs to timer i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 7 | Timer index [6:5], register [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 4 | Pending interrupt per timer |
| cfg_err | output | 1 | One-cycle flag for a rejected control write |

## Verification
Two events can fall on the same clock edge: a bus access to a timer, and that timer's own count step. The sharpest case is a clear write that lands on the edge where the counter would reach zero. The bench sets this up by writing a periodic timer's load with 2 and placing the clear so that it is captured on the second edge. The check expects no interrupt after that edge, a counter of 1 one clock later, and the interrupt one clock after that. A rejected control write is also judged against a pending interrupt that must survive it.

// File: rtl/cdt_bank.sv
module cdt_bank #(
  parameter int CW    = 24,
  parameter int DW    = 32,
  parameter int DIV_A = 4,
  parameter int DIV_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [6:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [3:0]    irq,
  output logic          cfg_err
);
  localparam int NT = 4;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [2:0] RG_LOAD = 3'd0, RG_VAL = 3'd1, RG_CTL = 3'd2, RG_CLR = 3'd3;

  logic [DIV_B-1:0]          pre_q;
  logic [NT-1:0][CW-1:0]     load_q, cnt_q;
  logic [NT-1:0][3:0]        ctl_q;
  logic [NT-1:0]             armed_q, pend_q;

  wire [1:0] idx   = bus_addr[6:5];
  wire [2:0] rsel  = bus_addr[4:2];
  wire tick_a      = &pre_q[DIV_A-1:0];
  wire tick_b      = &pre_q;
  wire bad_rate    = bus_wdata[2] & bus_wdata[3];
  wire unused_bits = ^{bus_wdata[DW-1:CW], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= bus_sel & bus_wr & (rsel == RG_CTL) & bad_rate;

  always_comb begin
    bus_rdata = '0;
    case (rsel)
      RG_LOAD: bus_rdata = DW'(load_q[idx]);
      RG_VAL:  bus_rdata = DW'(cnt_q[idx]);
      RG_CTL:  bus_rdata = DW'(ctl_q[idx]);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = pend_q;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    wire hit     = bus_sel && (idx == i);
    wire wr_load = hit && bus_wr && (rsel == RG_LOAD);
    wire wr_val  = hit && bus_wr && (rsel == RG_VAL);
    wire wr_ctl  = hit && bus_wr && (rsel == RG_CTL) && !bad_rate;
    wire clr     = hit && (rsel == RG_CLR);
    wire step    = ctl_q[i][3] ? tick_b : (ctl_q[i][2] ? tick_a : 1'b1);
    wire [CW-1:0] nxt = (cnt_q[i] == '0) ? '0 : cnt_q[i] - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q[i]  <= CMAX;
        cnt_q[i]   <= '0;
        ctl_q[i]   <= 4'h2;
        armed_q[i] <= 1'b0;
        pend_q[i]  <= 1'b0;
      end else if (wr_load) begin
        load_q[i]  <= bus_wdata[CW-1:0];
        cnt_q[i]   <= bus_wdata[CW-1:0];
        armed_q[i] <= 1'b1;
        pend_q[i]  <= 1'b0;
      end else if (wr_val) begin
        cnt_q[i]   <= bus_wdata[CW-1:0];
      end else if (wr_ctl) begin
        ctl_q[i]   <= bus_wdata[3:0];
        pend_q[i]  <= 1'b0;
        if (bus_wdata[0]) begin
          cnt_q[i]   <= load_q[i];
          armed_q[i] <= 1'b1;
        end
      end else if (clr) begin
        pend_q[i] <= 1'b0;
        if (ctl_q[i][1]) begin
          cnt_q[i]   <= load_q[i];
          armed_q[i] <= 1'b1;
        end
      end else if (armed_q[i] && step) begin
        cnt_q[i] <= nxt;
        if (nxt == '0) begin
          armed_q[i] <= 1'b0;
          if (ctl_q[i][0]) pend_q[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cdt_bank_chk.sv
module cdt_bank_chk #(
  parameter int CW = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic [6:0]          bus_addr,
  input logic [3:0]          irq,
  input logic                cfg_err,
  input logic [3:0][CW-1:0]  cnt_q,
  input logic [3:0][3:0]     ctl_q,
  input logic [3:0]          armed_q
);
  AST_ERR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ctl_q == $past(ctl_q)); // R6

  for (genvar i = 0; i < 4; i++) begin : g_chk
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(ctl_q[i][0])); // R8
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> (cnt_q[i] == '0) && !armed_q[i]); // R8
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_sel) && $past(cnt_q[i]) == '0) |-> cnt_q[i] == '0); // R8
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && bus_addr[6:5] == i && bus_addr[4:2] == 3'd3) |-> !irq[i]); // R9
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_sel) && $past(armed_q[i]) && cnt_q[i] != $past(cnt_q[i]))
        |-> cnt_q[i] == $past(cnt_q[i]) - CW'(1)); // R7
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_sel) && !$past(armed_q[i])) |-> $stable(cnt_q[i])); // R8
  end
endmodule

bind cdt_bank cdt_bank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .irq(irq), .cfg_err(cfg_err), .cnt_q(cnt_q), .ctl_q(ctl_q), .armed_q(armed_q)
);

// File: tb/test_cdt_bank.sv
`timescale 1ns/1ps
module test_cdt_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        cfg_err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cdt_bank i_cdt_bank (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq, .cfg_err);

  // {write, addr, data, expected read}
  localparam logic [71:0] VEC [9] = '{
    {1'b0, 7'h00, 32'h0,         32'h00FFFFFF},
    {1'b0, 7'h28, 32'h0,         32'h00000002},
    {1'b0, 7'h64, 32'h0,         32'h00000000},
    {1'b1, 7'h44, 32'hAB123456,  32'h0},
    {1'b0, 7'h44, 32'h0,         32'h00123456},
    {1'b0, 7'h40, 32'h0,         32'h00FFFFFF},
    {1'b1, 7'h68, 32'h00000008,  32'h0},
    {1'b0, 7'h68, 32'h0,         32'h00000008},
    {1'b0, 7'h0C, 32'h0,         32'h00000000}
  };

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R2 reset irq", {28'b0, irq}, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 9; k++) begin
      if (VEC[k][71]) wr(VEC[k][70:64], VEC[k][63:32]);
      else begin
        rd(VEC[k][70:64], d);
        chk($sformatf("R1 R2 R4 vector %0d", k), d, VEC[k][31:0]);
      end
    end

    // one-shot base rate: R3 R7 R8
    wr(7'h08, 32'h1);
    wr(7'h00, 32'h01000003);
    repeat (2) @(negedge clk);
    chk("R7 no irq before third step", {28'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 R11 irq at zero", {28'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    rd(7'h04, d); chk("R8 value saturates", d, 32'h0);
    chk("R8 irq held", {31'b0, irq[0]}, 32'h1);
    rd(7'h00, d); chk("R3 load masked", d, 32'h3);

    // one-shot clear: R9
    wr(7'h0C, 32'h0);
    chk("R9 clear drops irq", {31'b0, irq[0]}, 32'h0);
    repeat (10) @(negedge clk);
    rd(7'h04, d); chk("R9 one-shot stays zero", d, 32'h0);
    chk("R9 one-shot no refire", {31'b0, irq[0]}, 32'h0);

    // control enable rearm: R5
    wr(7'h08, 32'h1);
    rd(7'h04, d); chk("R5 control copies load", d, 32'h2);
    @(negedge clk);
    chk("R5 rearmed fires", {31'b0, irq[0]}, 32'h1);
    wr(7'h08, 32'h0);
    chk("R5 control write drops irq", {31'b0, irq[0]}, 32'h0);

    // enable off: R2 R8
    wr(7'h00, 32'h2);
    repeat (6) @(negedge clk);
    chk("R8 no irq when disabled", {31'b0, irq[0]}, 32'h0);
    rd(7'h04, d); chk("R8 counted to zero", d, 32'h0);

    // periodic: R9
    wr(7'h08, 32'h3);
    repeat (2) @(negedge clk);
    chk("R9 periodic fires", {31'b0, irq[0]}, 32'h1);
    repeat (4) @(negedge clk);
    rd(7'h04, d); chk("R9 no reload without clear", d, 32'h0);
    wr(7'h0C, 32'h0);
    chk("R9 periodic clear drops irq", {31'b0, irq[0]}, 32'h0);
    rd(7'h04, d); chk("R9 periodic reloaded", d, 32'h1);
    chk("R9 periodic refires", {31'b0, irq[0]}, 32'h1);
    wr(7'h08, 32'h0);

    // collision clear vs zero step: R10
    wr(7'h28, 32'h3);
    wr(7'h20, 32'h2);
    wr(7'h2C, 32'h0);
    chk("R10 clear wins over step", {28'b0, irq}, 32'h0);
    rd(7'h24, d); chk("R10 reload then one step", d, 32'h1);
    chk("R10 R11 fires later", {28'b0, irq}, 32'h2);

    // illegal rate: R6
    wr(7'h28, 32'hD);
    chk("R6 cfg_err pulse", {31'b0, cfg_err}, 32'h1);
    rd(7'h28, d); chk("R6 control unchanged", d, 32'h3);
    chk("R6 cfg_err one cycle", {31'b0, cfg_err}, 32'h0);
    chk("R6 irq kept", {31'b0, irq[1]}, 32'h1);

    // value overwrite while armed: R4
    wr(7'h48, 32'h1);
    wr(7'h44, 32'h5);
    rd(7'h40, d); chk("R4 load untouched", d, 32'h00FFFFFF);
    repeat (2) @(negedge clk);
    chk("R4 not yet", {31'b0, irq[2]}, 32'h0);
    @(negedge clk);
    chk("R4 fires from written value", {31'b0, irq[2]}, 32'h1);

    // divide-by-16 and divide-by-256: R7
    wr(7'h68, 32'h5);
    wr(7'h60, 32'h2);
    repeat (16) @(negedge clk);
    chk("R7 div16 early", {31'b0, irq[3]}, 32'h0);
    repeat (16) @(negedge clk);
    chk("R7 div16 fired", {31'b0, irq[3]}, 32'h1);
    wr(7'h68, 32'h9);
    wr(7'h60, 32'h2);
    repeat (256) @(negedge clk);
    chk("R7 div256 early", {31'b0, irq[3]}, 32'h0);
    repeat (256) @(negedge clk);
    chk("R7 div256 fired", {31'b0, irq[3]}, 32'h1);

    // unmapped and read-clear: R1 R9
    wr(7'h10, 32'h55);
    rd(7'h10, d); chk("R1 unmapped reads zero", d, 32'h0);
    rd(7'h00, d); chk("R1 unmapped write ignored", d, 32'h2);
    rd(7'h6C, d); chk("R1 clear reads zero", d, 32'h0);
    chk("R9 read of clear acks", {31'b0, irq[3]}, 32'h0);

    // reset mid-run: R2
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R2 reset clears irq", {28'b0, irq}, 32'h0);
    bus_addr = 7'h48; #1 chk("R2 reset control", bus_rdata, 32'h2);
    bus_addr = 7'h20; #1 chk("R2 reset load", bus_rdata, 32'h00FFFFFF);
    @(negedge clk); rst_n = 1'b1;

    finish_run();
  end
endmodule